// File: doc/BRIEF.md
# RGB Bit-Plane Transposer

This block takes a stream of 24-bit true-colour pixels, one per cycle whenever the input valid flag is high. It regroups them into bit-plane words. In the word it produces, each 8-bit colour lane holds the bits of one weight, taken from eight consecutive pixels of that colour. The red, green and blue lanes each perform an 8×8 bit transpose of their own, side by side. A later stage can then store or display every weight of a group on its own, as a separate plane. This is the basis for grayscale by field weighting or by duty cycle.

Each lane keeps two register banks. One bank collects the next eight pixels while the other bank sends out its eight planes. The input therefore never stalls. The block emits exactly one plane word for each valid pixel it accepts. A group that is only partly received is held until its eighth pixel arrives.

Top module: `bp_transposer`

## Requirements
- R1: While reset (`rst`, synchronous, active high) is asserted, and in the first cycle after it is released, `out_valid` is 0 and `out_data` is all zeros.
- R2: Input lane positions are red at bits 23..16, green at bits 15..8 and blue at bits 7..0. Each output lane sits at the same bit positions and carries only bits of its own colour.
- R3: Within each lane of a plane word for weight p, output bit j (0..7) equals bit p of the j-th pixel of the group. Index 0 is the first pixel received.
- R4: The eight plane words of a group appear on consecutive cycles, in ascending weight order from 0 to 7.
- R5: Suppose the eighth pixel of a group is sampled at clock edge T. Then the weight-0 word is presented after edge T+1, and `out_valid` stays high for exactly 8 cycles per group.
- R6: Cycles with `in_valid` low neither advance the group nor change its contents, whatever `in_data` holds. A partial group produces no output until it is completed.
- R7: Groups that arrive back to back are output without loss or gap. The next group fills while the previous one drains, so a continuous input gives a continuous `out_valid`.
- R8: Whenever `out_valid` is 0, `out_data` is all zeros.
- R9: A reset in the middle of a group discards the pixels already received. The next eight valid pixels form a new group.
- R10: Seven pixels of 00h followed by one pixel of 02h in a lane give exactly one nonzero word in that lane, the weight-1 plane, with only bit 7 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `in_data` in this cycle |
| in_data | input | 24 | Pixel: red 23..16, green 15..8, blue 7..0 |
| out_valid | output | 1 | Marks a plane word on `out_data` |
| out_data | output | 24 | Plane word: one weight of eight pixels per colour lane |

## Verification
The bench builds the block with its default parameters: three lanes of 8 bits, so groups of 8 pixels and 8 planes per group. These are the sizes at which the transposition is square. A full fill-and-drain cycle then takes only eight accepted pixels. Bank hand-over under continuous input, gaps in the middle of a group, and resets with a partial group can therefore all be reached within a few dozen cycles each. Every plane word is compared against a transpose computed by the bench, and its arrival cycle is checked at the same time.

// File: rtl/bp_pkg.sv
package bp_pkg;

    // Default geometry: bits per colour and number of colour lanes.
    localparam int unsigned DEF_COLOR_W = 8;
    localparam int unsigned DEF_LANES   = 3;

    // Which of the two register banks a lane is using.
    typedef enum logic [0:0] {
        BANK_A = 1'b0,
        BANK_B = 1'b1
    } bank_e;

    // Write-side event produced by the fill controller each cycle.
    typedef struct packed {
        logic  wr_en;       // store the incoming pixel
        bank_e bank;        // bank being filled
        logic  group_done;  // this pixel completes the group
    } fill_evt_t;

    // Read-side state produced by the drain controller.
    typedef struct packed {
        logic  active;      // a bank is being emitted plane by plane
        bank_e bank;        // bank being emitted
    } drain_t;

    function automatic bank_e flip_bank(input bank_e b);
        return (b == BANK_A) ? BANK_B : BANK_A;
    endfunction

endpackage

// File: rtl/bp_fill_ctrl.sv
module bp_fill_ctrl
    import bp_pkg::*;
#(
    parameter int unsigned GROUP = DEF_COLOR_W,
    localparam int unsigned IDX_W = (GROUP > 1) ? $clog2(GROUP) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic [IDX_W-1:0] wr_idx,
    output fill_evt_t        evt
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GROUP - 1);

    logic [IDX_W-1:0] idx_q;
    bank_e            bank_q;

    always_comb begin
        evt.wr_en      = in_valid;
        evt.bank       = bank_q;
        evt.group_done = in_valid && (idx_q == LAST_IDX);
        wr_idx         = idx_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            bank_q <= BANK_A;
        end else if (in_valid) begin
            if (idx_q == LAST_IDX) begin
                idx_q  <= '0;
                bank_q <= flip_bank(bank_q);
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/bp_drain_ctrl.sv
module bp_drain_ctrl
    import bp_pkg::*;
#(
    parameter int unsigned PLANES = DEF_COLOR_W,
    localparam int unsigned PL_W = (PLANES > 1) ? $clog2(PLANES) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  fill_evt_t       evt,
    output drain_t          drain,
    output logic [PL_W-1:0] plane
);

    localparam logic [PL_W-1:0] LAST_PL = PL_W'(PLANES - 1);

    drain_t          st_q;
    logic [PL_W-1:0] plane_q;

    assign drain = st_q;
    assign plane = plane_q;

    // A completed group always restarts the drain; with at most one pixel
    // per cycle the previous drain is on its last plane at that moment.
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.active <= 1'b0;
            st_q.bank   <= BANK_A;
            plane_q     <= '0;
        end else if (evt.group_done) begin
            st_q.active <= 1'b1;
            st_q.bank   <= evt.bank;
            plane_q     <= '0;
        end else if (st_q.active) begin
            if (plane_q == LAST_PL) begin
                st_q.active <= 1'b0;
                plane_q     <= '0;
            end else begin
                plane_q <= plane_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/bp_lane.sv
module bp_lane
    import bp_pkg::*;
#(
    parameter int unsigned W = DEF_COLOR_W,
    localparam int unsigned IDX_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  fill_evt_t        evt,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     din,
    input  bank_e            rd_bank,
    input  logic [IDX_W-1:0] rd_plane,
    output logic [W-1:0]     dout
);

    // Two banks of W pixels, each W bits wide.
    logic [W-1:0] mem_q [2][W];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < 2; b++) begin
                for (int j = 0; j < W; j++) begin
                    mem_q[b][j] <= '0;
                end
            end
        end else if (evt.wr_en) begin
            mem_q[evt.bank][wr_idx] <= din;
        end
    end

    // Bit selector: gather bit weight rd_plane of every stored pixel.
    always_comb begin
        for (int j = 0; j < W; j++) begin
            dout[j] = mem_q[rd_bank][j][rd_plane];
        end
    end

endmodule

// File: rtl/bp_transposer.sv
module bp_transposer
    import bp_pkg::*;
#(
    parameter int unsigned COLOR_W = DEF_COLOR_W,
    parameter int unsigned LANES   = DEF_LANES,
    localparam int unsigned DATA_W = COLOR_W * LANES,
    localparam int unsigned IDX_W  = (COLOR_W > 1) ? $clog2(COLOR_W) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    fill_evt_t        evt;
    logic [IDX_W-1:0] wr_idx;
    drain_t           drain;
    logic [IDX_W-1:0] plane;
    logic [DATA_W-1:0] plane_word;

    bp_fill_ctrl #(.GROUP(COLOR_W)) u_fill (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .wr_idx   (wr_idx),
        .evt      (evt)
    );

    bp_drain_ctrl #(.PLANES(COLOR_W)) u_drain (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt),
        .drain (drain),
        .plane (plane)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        bp_lane #(.W(COLOR_W)) u_lane (
            .clk      (clk),
            .rst      (rst),
            .evt      (evt),
            .wr_idx   (wr_idx),
            .din      (in_data[l*COLOR_W +: COLOR_W]),
            .rd_bank  (drain.bank),
            .rd_plane (plane),
            .dout     (plane_word[l*COLOR_W +: COLOR_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= drain.active;
            out_data  <= drain.active ? plane_word : '0;
        end
    end

endmodule

// File: rtl/bp_transposer_chk.sv
module bp_transposer_chk #(
    parameter int unsigned COLOR_W = 8,
    parameter int unsigned LANES   = 3,
    localparam int unsigned DATA_W = COLOR_W * LANES,
    localparam int unsigned CNT_W  = (COLOR_W > 1) ? $clog2(COLOR_W) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(COLOR_W - 1);

    logic [CNT_W-1:0] acc_q;   // accepted pixels modulo group size
    logic [CNT_W-1:0] run_q;   // out_valid cycles modulo group size

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            run_q <= '0;
        end else begin
            if (in_valid) acc_q <= (acc_q == LAST) ? '0 : acc_q + 1'b1;
            if (out_valid) run_q <= (run_q == LAST) ? '0 : run_q + 1'b1;
            else           run_q <= '0;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_data == '0));

    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_data == '0));

    assert_whole_groups_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(out_valid) |-> (run_q == '0));

    assert_start_after_group_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> ($past(in_valid, 2) && $past(acc_q, 2) == LAST));

endmodule

bind bp_transposer bp_transposer_chk #(.COLOR_W(COLOR_W), .LANES(LANES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/bp_transposer_bench.sv
module bp_transposer_bench;

    localparam int W = 8;
    localparam int L = 3;
    localparam int D = W * L;
    localparam int NV = 28;

    // {valid, pixel}
    localparam logic [D:0] VEC [0:NV-1] = '{
        25'h1800001, 25'h1400002, 25'h1200004, 25'h1100008,
        25'h1080010, 25'h1040020, 25'h1020040, 25'h1010080,
        25'h13C5AA5, 25'h0FFFFFF, 25'h1123456, 25'h189ABCD,
        25'h0A5A5A5, 25'h1FEDCBA, 25'h10F0F0F, 25'h0777777,
        25'h1F0F0F0, 25'h155AA33, 25'h0FFFFFF, 25'h1C3E71D,
        25'h17E8100, 25'h100FF00, 25'h1A5A5A5, 25'h15A5A5A,
        25'h113579B, 25'h12468AC, 25'h1DEADBE, 25'h10BADF0
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [D-1:0] in_data = '0;
    logic out_valid;
    logic [D-1:0] out_data;

    always #4 clk = ~clk;

    bp_transposer u_bp_transposer (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [D-1:0] grp [0:W-1];
    int n = 0;
    logic [D-1:0] exp_word [0:255];
    int exp_cyc [0:255];
    logic [D-1:0] got_word [0:255];
    int wr = 0;
    int rd = 0;

    // Expected planes of a full group: lane l, bit j = bit p of pixel j.
    task automatic push_group(input int done_cyc);
        for (int p = 0; p < W; p++) begin
            logic [D-1:0] w;
            w = '0;
            for (int l = 0; l < L; l++)
                for (int j = 0; j < W; j++)
                    w[l*W + j] = grp[j][l*W + p];
            exp_word[wr] = w;
            exp_cyc[wr]  = done_cyc + 2 + p;
            wr++;
        end
    endtask

    task automatic drive(input logic v, input logic [D-1:0] px);
        @(negedge clk);
        in_valid = v;
        in_data  = px;
        if (v) begin
            grp[n] = px;
            n++;
            if (n == W) begin
                push_group(cyc);
                n = 0;
            end
        end
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) drive(1'b0, '1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        n = 0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [D-1:0] act, input logic [D-1:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // Output monitor: every plane word against the bench transpose and cycle.
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                checks++;
                if (rd >= wr) begin
                    fails++;
                    $display("FAIL R6 unexpected word: actual=%h expected=none", out_data);
                end else begin
                    got_word[rd] = out_data;
                    if (out_data !== exp_word[rd]) begin
                        fails++;
                        $display("FAIL R3 R4 word %0d: actual=%h expected=%h",
                                 rd, out_data, exp_word[rd]);
                    end else if (cyc != exp_cyc[rd]) begin
                        fails++;
                        $display("FAIL R5 word %0d cycle: actual=%0d expected=%0d",
                                 rd, cyc, exp_cyc[rd]);
                    end
                    rd++;
                end
            end else if (out_data !== '0) begin
                checks++;
                fails++;
                $display("FAIL R8 idle data: actual=%h expected=0", out_data);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R5 watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int base;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R1", "valid in reset", {23'b0, out_valid}, '0);
        check(out_data === '0, "R1", "data in reset", out_data, '0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid === 1'b0 && out_data === '0, "R1", "after release", out_data, '0);

        // Table walk: R3 R4 R5 R6 R7 (gaps with junk data, back-to-back groups)
        for (int i = 0; i < NV; i++) drive(VEC[i][D], VEC[i][D-1:0]);
        idle(12);

        // R10: seven zero pixels then 02h in the blue lane
        base = wr;
        for (int i = 0; i < 7; i++) drive(1'b1, 24'h000000);
        drive(1'b1, 24'h000002);
        idle(12);
        check(got_word[base+1] === 24'h000080, "R10", "weight-1 plane",
              got_word[base+1], 24'h000080);
        for (int p = 0; p < W; p++)
            if (p != 1)
                check(got_word[base+p] === '0, "R10", "other plane zero",
                      got_word[base+p], '0);

        // R2: red all ones, green 0Fh, blue zero
        base = wr;
        for (int i = 0; i < W; i++) drive(1'b1, 24'hFF0F00);
        idle(12);
        check(got_word[base] === 24'hFFFF00, "R2", "plane 0 lanes", got_word[base], 24'hFFFF00);
        check(got_word[base+7] === 24'hFF0000, "R2", "plane 7 lanes", got_word[base+7], 24'hFF0000);

        // R6: partial group held across a long idle, then completed
        for (int i = 0; i < 5; i++) drive(1'b1, 24'h11 << i);
        for (int i = 0; i < 20; i++) begin
            drive(1'b0, 24'hABCDEF);
            check(out_valid === 1'b0, "R6", "partial group quiet", {23'b0, out_valid}, '0);
        end
        for (int i = 0; i < 3; i++) drive(1'b1, 24'hC0FFEE ^ i);
        idle(12);

        // R9: reset with a partial group, then a fresh group
        for (int i = 0; i < 5; i++) drive(1'b1, 24'hFFFFFF);
        do_reset();
        @(negedge clk);
        check(out_valid === 1'b0, "R1", "after mid reset", {23'b0, out_valid}, '0);
        for (int i = 0; i < W; i++) drive(1'b1, 24'h010203 * (i + 1));
        idle(12);

        // R7: three groups fully back to back
        for (int i = 0; i < 3 * W; i++) drive(1'b1, 24'h9E3779 * (i + 7));
        idle(14);

        check(rd == wr, "R7", "all words delivered", D'(rd), D'(wr));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule